// File: doc/BRIEF.md
# RV32I Immediate Generator

This block turns a 32-bit base-integer instruction word into the 32-bit sign-extended immediate that the execute stage feeds to the ALU, the branch target adder or the address adder. The control decoder chooses the format and drives it on a 3-bit select. The block does not look at the opcode itself.

The block is purely combinational. The output follows the inputs within the same cycle and holds no state. Most immediate bits always come from the same instruction bit. Only the low bits, bit 11 and the middle band change source between formats. The design uses a small AND-OR multiplexer for each bit segment, steered by a one-hot decode of the select. A select code that is not assigned gives an all-zero immediate.

Top module: `rvimm_gen`

## Requirements
- R1: With select code 0 (I), imm[11:0] equals inst[31:20] and imm[31:12] are copies of inst[31].
- R2: With select code 1 (S), imm[11:5] equals inst[31:25], imm[4:0] equals inst[11:7], and imm[31:12] are copies of inst[31].
- R3: With select code 2 (B), imm[12] equals inst[31], imm[11] equals inst[7], imm[10:5] equals inst[30:25], imm[4:1] equals inst[11:8], imm[0] is 0, and imm[31:13] are copies of inst[31]. The value is an even byte offset in the range -4096 to +4094.
- R4: With select code 3 (J), imm[20] equals inst[31], imm[19:12] equals inst[19:12], imm[11] equals inst[20], imm[10:1] equals inst[30:21], imm[0] is 0, and imm[31:21] are copies of inst[31].
- R5: With select code 4 (U), imm[31:12] equals inst[31:12] and imm[11:0] is zero.
- R6: For select codes 0 to 3, imm[31:20] all equal inst[31], whatever the other instruction bits are.
- R7: Select codes 5, 6 and 7 give an all-zero immediate for any instruction word.
- R8: The output reflects the current instruction and select in the same cycle, with no register on the path. A change of select alone changes the output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word being decoded |
| fmt_i | input | 3 | Immediate format select from the control decoder (0=I, 1=S, 2=B, 3=J, 4=U) |
| imm_o | output | 32 | Assembled, sign-extended immediate |

## Verification
Some properties can be checked on every evaluation, whatever the instruction word: the sign band copying inst[31] for the four signed formats, a zero bit 0 for B and J, zero low bits for U, the S field placement, and an all-zero output for unassigned codes. Whether every bit lands in the right place for each format can only be shown by the bench's sweeps. These compare the output against a value the bench assembles independently and shifts arithmetically, using walking-one words, walking-zero words and a large random set per format. The same-cycle response to a select change alone (R8) is also shown only by the bench.

// File: rtl/rvimm_pkg.sv
// Shared definitions for the immediate generator.
// Assumes a 32-bit instruction word and a 32-bit datapath.
package rvimm_pkg;
    localparam int INST_W = 32;
    localparam int IMM_W  = 32;
    localparam int SEL_W  = 3;
    localparam int NFMT   = 5;

    typedef enum logic [SEL_W-1:0] {
        FMT_I = 3'd0,
        FMT_S = 3'd1,
        FMT_B = 3'd2,
        FMT_J = 3'd3,
        FMT_U = 3'd4
    } imm_fmt_e;

    // Index of each format inside the one-hot steering vector
    localparam int HOT_I = 0;
    localparam int HOT_S = 1;
    localparam int HOT_B = 2;
    localparam int HOT_J = 3;
    localparam int HOT_U = 4;
endpackage

// File: rtl/rvimm_fmt_dec.sv
// Converts the format select code into a one-hot steering vector.
// Assumes codes above FMT_U are unused; they yield an all-zero vector,
// which forces every segment multiplexer to output zero.
module rvimm_fmt_dec
    import rvimm_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output logic [NFMT-1:0]  hot_o
);
    // One-hot decode of the select; unused codes select nothing
    always_comb begin
        hot_o = '0;
        for (int f = 0; f < NFMT; f++) begin
            if (sel_i == SEL_W'(f)) hot_o[f] = 1'b1;
        end
    end
endmodule

// File: rtl/rvimm_seg_mux.sv
// AND-OR multiplexer for one segment of the immediate.
// Assumes hot_i is one-hot or all zero; all zero gives a zero segment.
module rvimm_seg_mux
    import rvimm_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [NFMT-1:0] hot_i,
    input  logic [W-1:0]    src_i_i,
    input  logic [W-1:0]    src_s_i,
    input  logic [W-1:0]    src_b_i,
    input  logic [W-1:0]    src_j_i,
    input  logic [W-1:0]    src_u_i,
    output logic [W-1:0]    seg_o
);
    logic [NFMT-1:0][W-1:0] src;

    assign src[HOT_I] = src_i_i;
    assign src[HOT_S] = src_s_i;
    assign src[HOT_B] = src_b_i;
    assign src[HOT_J] = src_j_i;
    assign src[HOT_U] = src_u_i;

    // OR together the sources whose format is selected
    always_comb begin
        seg_o = '0;
        for (int f = 0; f < NFMT; f++) begin
            seg_o = seg_o | (src[f] & {W{hot_i[f]}});
        end
    end
endmodule

// File: rtl/rvimm_gen.sv
// Immediate generator for the 32-bit base integer instruction set.
// Purely combinational: the immediate is split into segments whose
// sources are fixed per format, and each segment has its own small
// multiplexer. Sign fill always comes from instruction bit 31.
// Assumes the format select comes from the control decoder.
module rvimm_gen
    import rvimm_pkg::*;
(
    input  logic [INST_W-1:0] inst_i,
    input  logic [SEL_W-1:0]  fmt_i,
    output logic [IMM_W-1:0]  imm_o
);
    logic [NFMT-1:0] hot;
    logic            sgn;
    logic            unused_opcode;

    assign sgn           = inst_i[31];
    assign unused_opcode = ^inst_i[6:0];

    rvimm_fmt_dec u_dec (
        .sel_i (fmt_i),
        .hot_o (hot)
    );

    // bit 0: only I and S carry it; B, J, U force zero
    rvimm_seg_mux #(.W(1)) u_b0 (
        .hot_i(hot), .src_i_i(inst_i[20]), .src_s_i(inst_i[7]),
        .src_b_i(1'b0), .src_j_i(1'b0), .src_u_i(1'b0),
        .seg_o(imm_o[0])
    );

    // bits 4:1: register-source field (I, J) or store/branch field (S, B)
    rvimm_seg_mux #(.W(4)) u_b4_1 (
        .hot_i(hot), .src_i_i(inst_i[24:21]), .src_s_i(inst_i[11:8]),
        .src_b_i(inst_i[11:8]), .src_j_i(inst_i[24:21]), .src_u_i(4'd0),
        .seg_o(imm_o[4:1])
    );

    // bits 10:5: fixed at inst[30:25] for every signed format
    rvimm_seg_mux #(.W(6)) u_b10_5 (
        .hot_i(hot), .src_i_i(inst_i[30:25]), .src_s_i(inst_i[30:25]),
        .src_b_i(inst_i[30:25]), .src_j_i(inst_i[30:25]), .src_u_i(6'd0),
        .seg_o(imm_o[10:5])
    );

    // bit 11: sign for I/S, inst[7] for B, inst[20] for J
    rvimm_seg_mux #(.W(1)) u_b11 (
        .hot_i(hot), .src_i_i(sgn), .src_s_i(sgn),
        .src_b_i(inst_i[7]), .src_j_i(inst_i[20]), .src_u_i(1'b0),
        .seg_o(imm_o[11])
    );

    // bits 19:12: sign fill except for J and U, which take inst[19:12]
    rvimm_seg_mux #(.W(8)) u_b19_12 (
        .hot_i(hot), .src_i_i({8{sgn}}), .src_s_i({8{sgn}}),
        .src_b_i({8{sgn}}), .src_j_i(inst_i[19:12]), .src_u_i(inst_i[19:12]),
        .seg_o(imm_o[19:12])
    );

    // bits 30:20: sign fill except for U, which takes inst[30:20]
    rvimm_seg_mux #(.W(11)) u_b30_20 (
        .hot_i(hot), .src_i_i({11{sgn}}), .src_s_i({11{sgn}}),
        .src_b_i({11{sgn}}), .src_j_i({11{sgn}}), .src_u_i(inst_i[30:20]),
        .seg_o(imm_o[30:20])
    );

    // bit 31: always inst[31] for any assigned format
    rvimm_seg_mux #(.W(1)) u_b31 (
        .hot_i(hot), .src_i_i(sgn), .src_s_i(sgn),
        .src_b_i(sgn), .src_j_i(sgn), .src_u_i(sgn),
        .seg_o(imm_o[31])
    );
endmodule

// File: rtl/rvimm_gen_chk.sv
// Property checker for rvimm_gen. The block has no clock, so the
// checks are immediate assertions evaluated whenever the inputs or the
// output change. Assumes combinational ordering settles imm_o first.
module rvimm_gen_chk
    import rvimm_pkg::*;
(
    input logic [INST_W-1:0] inst_i,
    input logic [SEL_W-1:0]  fmt_i,
    input logic [IMM_W-1:0]  imm_o
);
    // Relate output bits to instruction bits per format
    always_comb begin
        if (fmt_i <= 3'd3)
            AST_SIGN_BAND: assert (imm_o[31:20] == {12{inst_i[31]}}); // R6
        if (fmt_i == 3'd2 || fmt_i == 3'd3)
            AST_EVEN_OFFSET: assert (imm_o[0] == 1'b0); // R3
        if (fmt_i == 3'd4)
            AST_U_LOW_CLEAR: assert (imm_o[11:0] == 12'd0); // R5
        if (fmt_i > 3'd4)
            AST_UNUSED_ZERO: assert (imm_o == '0); // R7
        if (fmt_i == 3'd1)
            AST_S_FIELDS: assert (imm_o[11:0] == {inst_i[31:25], inst_i[11:7]}); // R2
    end
endmodule

bind rvimm_gen rvimm_gen_chk u_chk (
    .inst_i (inst_i),
    .fmt_i  (fmt_i),
    .imm_o  (imm_o)
);

// File: tb/sim_rvimm_gen.sv
// Sweeps every format with walking-one, walking-zero and random words,
// and compares against a reference built by an arithmetic shift.
module sim_rvimm_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inst;
    logic [2:0]  fmt;
    logic [31:0] imm;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    rvimm_gen u0 (
        .inst_i (inst),
        .fmt_i  (fmt),
        .imm_o  (imm)
    );

    // Reference immediate, built independently of the RTL layout
    function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic [2:0] f);
        logic signed [31:0] t;
        case (f)
            3'd0: begin t = {w[31:20], 20'd0}; return 32'(t >>> 20); end
            3'd1: begin t = {w[31:25], w[11:7], 20'd0}; return 32'(t >>> 20); end
            3'd2: begin t = {w[31], w[7], w[30:25], w[11:8], 1'b0, 19'd0}; return 32'(t >>> 19); end
            3'd3: begin t = {w[31], w[19:12], w[20], w[30:21], 1'b0, 11'd0}; return 32'(t >>> 11); end
            3'd4: return {w[31:12], 12'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        total++;
        if (imm !== exp) begin
            bad++;
            $display("FAIL %s inst=%h fmt=%0d actual=%h expected=%h", tag, inst, fmt, imm, exp);
        end
    endtask

    // Drive on the falling edge, compare one time step later
    task automatic apply(input logic [31:0] w, input logic [2:0] f);
        @(negedge clk);
        inst = w;
        fmt  = f;
        #1;
        check(tag_of(f), ref_imm(w, f));
        if (f <= 3'd3 && imm[31:20] !== {12{w[31]}}) begin
            total++; bad++;
            $display("FAIL R6 inst=%h fmt=%0d actual=%h expected sign band %h", w, f, imm[31:20], {12{w[31]}});
        end
    endtask

    initial begin
        inst = 32'd0;
        fmt  = 3'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero word in I gives zero (R1)
        @(negedge clk); #1;
        check("R1", 32'd0);
        // Extreme words for every code
        for (int f = 0; f < 8; f++) begin
            apply(32'hFFFF_FFFF, 3'(f));
            apply(32'h0000_0000, 3'(f));
            apply(32'h8000_0000, 3'(f));
            apply(32'h7FFF_FFFF, 3'(f));
        end
        // B range limits: -4096 and +4094 (R3)
        apply(32'h8000_0000, 3'd2); check("R3", 32'hFFFF_F000);
        apply(32'h7E00_0F80, 3'd2); check("R3", 32'h0000_0FFE);
        // Walking one and walking zero per code
        for (int f = 0; f < 8; f++) begin
            for (int b = 0; b < 32; b++) begin
                apply(32'd1 << b, 3'(f));
                apply(~(32'd1 << b), 3'(f));
            end
        end
        // Random sweep per code
        for (int f = 0; f < 8; f++) begin
            for (int n = 0; n < 1500; n++) apply($urandom, 3'(f));
        end
        // Select change alone updates output in the same cycle (R8)
        @(negedge clk);
        inst = 32'hA5C3_9F81;
        fmt  = 3'd0;
        #1; check("R8", ref_imm(32'hA5C3_9F81, 3'd0));
        fmt  = 3'd3;
        #1; check("R8", ref_imm(32'hA5C3_9F81, 3'd3));
        fmt  = 3'd6;
        #1; check("R8", 32'd0);
        done = 1'b1;
    end

    // Watchdog and single summary line
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule